// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block joins two bidirectional 8-bit buses, A and B, and keeps one storage register for each direction of transfer. The A-to-B register samples the A bus and the B-to-A register samples the B bus. Each register has its own capture line. A register takes a new word only on a low-to-high transition of its line. Capture runs whether or not either bus is being driven.

An active-low output enable and a direction input decide which bus is driven, if any. Each direction has a select input. It chooses whether the driven bus carries live data from the opposite bus or the word held in that direction's register. The live paths are combinational. Each bus is split into separate input, output and output-enable signals in place of tristate pins. A bus that is not driven carries all zeros on its output. One system clock samples both capture lines. Reset is asynchronous and active-low.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On a clock edge where cap_ab_i is 1 and was 0 at the previous edge, the A-to-B register loads a_i. The new value is visible on b_o from the following cycle when b_o shows the stored word.
- R2: On a clock edge where cap_ba_i is 1 and was 0 at the previous edge, the B-to-A register loads b_i. The new value is visible on a_o from the following cycle when a_o shows the stored word.
- R3: A capture line held at 1 or held at 0 over consecutive edges leaves its register unchanged.
- R4: Capture works whatever the values of oe_ni, dir_i, sel_ab_i and sel_ba_i, including while both buses are undriven.
- R5: While oe_ni is 1, a_oe_o and b_oe_o are both 0, and a_o and b_o are both zero.
- R6: While oe_ni is 0 and dir_i is 0, a_oe_o is 1 and b_oe_o is 0. The output of the undriven bus, b_o, is zero.
- R7: While oe_ni is 0 and dir_i is 1, b_oe_o is 1 and a_oe_o is 0. The output of the undriven bus, a_o, is zero.
- R8: While A is driven, a_o equals b_i in the same cycle when sel_ba_i is 0, and equals the B-to-A register when sel_ba_i is 1.
- R9: While B is driven, b_o equals a_i in the same cycle when sel_ab_i is 0, and equals the A-to-B register when sel_ab_i is 1.
- R10: a_oe_o and b_oe_o are never 1 together.
- R11: Reset clears both registers to zero and clears both capture-history bits, and both output enables are 0 while oe_ni is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the capture lines |
| rst_ni | input | 1 | Asynchronous reset, active-low |
| oe_ni | input | 1 | Output enable, active-low |
| dir_i | input | 1 | Direction: 0 drives A, 1 drives B |
| sel_ab_i | input | 1 | B output source: 0 is live A, 1 is the stored A-to-B word |
| sel_ba_i | input | 1 | A output source: 0 is live B, 1 is the stored B-to-A word |
| cap_ab_i | input | 1 | A-to-B capture line; loads on a rising transition |
| cap_ba_i | input | 1 | B-to-A capture line; loads on a rising transition |
| a_i | input | 8 | A bus sampled value |
| a_o | output | 8 | A bus drive value |
| a_oe_o | output | 1 | A bus drive enable |
| b_i | input | 8 | B bus sampled value |
| b_o | output | 8 | B bus drive value |
| b_oe_o | output | 1 | B bus drive enable |

## Verification
Directed runs come first. One stores a word while both buses are isolated and then reads it out on B, which separates capture from output gating. Another holds a capture line high while the bus keeps changing, which separates edge capture from level capture. A third reads both registers straight after reset, which shows whether the clear took effect. A long run of random control and data words then compares every output against a behavioural model in each cycle. The random data makes live and stored sources differ almost every time, so a wrong select or a wrong direction decode shows up as a value mismatch.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_e;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_AB  = 0;
  localparam int unsigned DIR_BA  = 1;
endpackage

// File: rtl/bus_capture_reg.sv
module bus_capture_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic         strobe_q;
  logic         load;
  logic [W-1:0] word_q;

  assign load = strobe_i & ~strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      word_q   <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (load) word_q <= d_i;
    end
  end

  assign q_o = word_q;

  // R1 / R2: a rising capture line loads the bus word
  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !strobe_q) |=> (q_o == $past(d_i)));

  // R3: a steady capture line keeps the word
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_i && !strobe_q) |=> $stable(q_o));
endmodule

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import xcvr_pkg::*;
(
  input  logic   oe_ni,
  input  logic   dir_i,
  output drive_e drive_o
);
  always_comb begin
    if (oe_ni)      drive_o = DRV_NONE;
    else if (dir_i) drive_o = DRV_B;
    else            drive_o = DRV_A;
  end
endmodule

// File: rtl/xcvr_out_mux.sv
module xcvr_out_mux #(
  parameter int unsigned W = 8
) (
  input  logic         en_i,
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] out_o
);
  always_comb begin
    if (!en_i)     out_o = '0;
    else if (sel_i) out_o = stored_i;
    else            out_o = live_i;
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         oe_ni,
  input  logic         dir_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic         cap_ab_i,
  input  logic         cap_ba_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  logic [NUM_DIR-1:0] strobe;
  logic [W-1:0]       din   [NUM_DIR];
  logic [W-1:0]       store [NUM_DIR];
  drive_e             drive;

  assign strobe[DIR_AB] = cap_ab_i;
  assign strobe[DIR_BA] = cap_ba_i;
  assign din[DIR_AB]    = a_i;
  assign din[DIR_BA]    = b_i;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    bus_capture_reg #(.W(W)) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (strobe[d]),
      .d_i      (din[d]),
      .q_o      (store[d])
    );
  end

  xcvr_dir_ctrl u_ctrl (
    .oe_ni   (oe_ni),
    .dir_i   (dir_i),
    .drive_o (drive)
  );

  assign a_oe_o = (drive == DRV_A);
  assign b_oe_o = (drive == DRV_B);

  xcvr_out_mux #(.W(W)) u_mux_a (
    .en_i     (a_oe_o),
    .sel_i    (sel_ba_i),
    .live_i   (b_i),
    .stored_i (store[DIR_BA]),
    .out_o    (a_o)
  );

  xcvr_out_mux #(.W(W)) u_mux_b (
    .en_i     (b_oe_o),
    .sel_i    (sel_ab_i),
    .live_i   (a_i),
    .stored_i (store[DIR_AB]),
    .out_o    (b_o)
  );

  p_one_side_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o));

  p_isolate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!a_oe_o && !b_oe_o && a_o == '0 && b_o == '0));

  p_live_a_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o && !sel_ba_i) |-> (a_o == b_i));

  p_live_b_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && !sel_ab_i) |-> (b_o == a_i));

  p_stored_b_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && sel_ab_i && $past(b_oe_o && sel_ab_i) && $stable(store[DIR_AB]))
      |-> $stable(b_o));
endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int PERIOD = 10;
  localparam int W = 8;
  localparam int N_RAND = 3000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic cap_ab = 1'b0, cap_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  int ref_ab = 0, ref_ba = 0;
  bit prev_ab = 0, prev_ba = 0;

  always #(PERIOD/2) clk = ~clk;

  bus_xcvr_reg #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .oe_ni(oe_n), .dir_i(dir),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .cap_ab_i(cap_ab), .cap_ba_i(cap_ba),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare all outputs with the model in the current cycle
  task automatic compare();
    int ea, eb, eaoe, eboe;
    eaoe = (!oe_n && !dir) ? 1 : 0;
    eboe = (!oe_n && dir) ? 1 : 0;
    ea = eaoe ? (sel_ba ? ref_ba : int'(b_in)) : 0;
    eb = eboe ? (sel_ab ? ref_ab : int'(a_in)) : 0;
    check(a_oe === eaoe[0], oe_n ? "R5" : "R6", a_oe, eaoe);
    check(b_oe === eboe[0], oe_n ? "R5" : "R7", b_oe, eboe);
    check(!(a_oe && b_oe), "R10", {a_oe, b_oe}, 0);
    check(a_out === ea[W-1:0], eaoe != 0 ? (sel_ba ? "R2" : "R8") : "R7", a_out, ea);
    check(b_out === eb[W-1:0], eboe != 0 ? (sel_ab ? "R1" : "R9") : "R6", b_out, eb);
  endtask

  // one clock: model updates from the inputs held across the edge
  task automatic step();
    @(posedge clk);
    if (rst_ni) begin
      if (cap_ab && !prev_ab) ref_ab = int'(a_in);
      if (cap_ba && !prev_ba) ref_ba = int'(b_in);
      prev_ab = cap_ab;
      prev_ba = cap_ba;
    end
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R11: registers cleared, outputs disabled while oe_n high
    #1;
    check(!a_oe && !b_oe && a_out == 0 && b_out == 0, "R11", {a_oe, b_oe, a_out, b_out}, 0);
    oe_n = 0; dir = 0; sel_ba = 1; b_in = 8'hC3; #1;
    check(a_out == 0, "R11", a_out, 0);
    dir = 1; sel_ab = 1; a_in = 8'h3C; #1;
    check(b_out == 0, "R11", b_out, 0);

    // R4: store A while isolated, then read stored word on B
    oe_n = 1; a_in = 8'h5A; cap_ab = 1; #1;
    compare();
    step();
    cap_ab = 0; a_in = 8'h11; #1;
    check(a_out == 0 && b_out == 0, "R5", {a_out, b_out}, 0);
    step();
    oe_n = 0; dir = 1; sel_ab = 1; #1;
    check(b_out == 8'h5A, "R4", b_out, 8'h5A);
    check(b_oe && !a_oe, "R7", {a_oe, b_oe}, 1);

    // R3: capture line held high, bus changes, word unchanged
    a_in = 8'h77; cap_ab = 1; step();
    a_in = 8'h88; step();
    a_in = 8'h99; step(); #1;
    check(b_out == 8'h77, "R3", b_out, 8'h77);
    cap_ab = 0; step(); #1;
    check(b_out == 8'h77, "R3", b_out, 8'h77);

    // R2: B captured with A driven from storage
    dir = 0; sel_ba = 1; b_in = 8'hE4; cap_ba = 1; #1;
    compare();
    step(); #1;
    check(a_out == 8'hE4, "R2", a_out, 8'hE4);
    cap_ba = 0; b_in = 8'h01; #1;
    check(a_out == 8'hE4, "R8", a_out, 8'hE4);
    sel_ba = 0; #1;
    check(a_out == 8'h01, "R8", a_out, 8'h01);

    // random sweep against the model
    for (int i = 0; i < N_RAND; i++) begin
      logic [31:0] r;
      r = $urandom;
      oe_n = (r[2:0] == 3'd0);
      dir = r[3]; sel_ab = r[4]; sel_ba = r[5];
      cap_ab = r[6] & r[7]; cap_ba = r[8] & r[9];
      a_in = r[23:16]; b_in = r[31:24];
      #1;
      compare();
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule